// File: doc/BRIEF.md
# Sleep-Retention Edge Interrupt Recorder

This block is a second-level interrupt stage placed between a set of external interrupt lines and a main interrupt controller that can lose power. While it is disabled, each line is passed through to the parent controller, gated only by its mask bit. Before the parent is powered down, software switches the block into recording mode (enable plus edge-only). In that mode every unmasked, edge-sensitive line is watched for its configured edge, and any such edge is held in a per-line pending latch. After power returns, software issues a flush command. The flush replays every held event to the parent as a single-cycle pulse and empties the latches.

Configuration is one bit per line in three banks: mask, sense and polarity. Each bank is written through a write-one-to-set window and a write-one-to-clear window. Lines are packed 32 to a 32-bit word, and words sit 4 bytes apart. The register interface is a plain synchronous memory-mapped bus. Read data is registered and is valid one cycle after the read strobe. Inputs pass through a two-flop synchronizer, and every output is registered.

Top module: `edge_rec_top`

## Requirements
- R1: After synchronous reset, every output line is 0, and the mask, sense, polarity and control registers all read 0.
- R2: Line n is controlled by bit n mod 32 of word n/32, and word k of a bank sits at bank base + 4k. The bank bases are mask-set 0x0C0, mask-clear 0x100, sense-set 0x180, sense-clear 0x1C0, polarity-set 0x240 and polarity-clear 0x280. Writing 1 to a set-window bit sets that configuration bit, writing 1 to a clear-window bit clears it, and 0 bits leave it unchanged.
- R3: A read of either window of a bank returns that bank's current word. The control register at 0x300 reads back bit 0 (enable) and bit 1 (edge-only), and bit 2 (flush) always reads 0. Addresses outside the map, and words beyond the last line, read 0 and ignore writes.
- R4: While enable is 0, each output follows its synchronized input ANDed with the inverse of its mask, three clock edges after the input changes, and all pending latches are held cleared.
- R5: In recording mode (enable=1 and edge-only=1), an unmasked edge-sensitive line (sense=0) sets its pending latch on a rising edge when its polarity bit is 1 and on a falling edge when it is 0. The opposite edge sets nothing.
- R6: A write to the control register with bit 2 set, made in recording mode, drives a one-cycle pulse on the output of every edge-sensitive line whose latch is pending and clears those latches. Edge-sensitive outputs stay 0 between flushes.
- R7: A masked line (mask=1) never sets its pending latch, and its pass-through output is held at 0.
- R8: In recording mode, a level-sensitive line (sense=1) passes its input through (gated by its mask) and never sets a pending latch.
- R9: An edge detected in the same cycle as a flush is not lost: it shows up in exactly one of that flush or the next one.
- R10: With enable=1 and edge-only=0, outputs pass through as in R4 and no edge is recorded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered, valid the cycle after bus_rd |
| irq_in | input | NUM_LINES | External interrupt lines (asynchronous) |
| irq_out | output | NUM_LINES | Lines to the parent controller |

## Verification
The in-line assertions check the following on every cycle:
- a flush empties every latch it replays, unless a new edge arrives at the same moment;
- the latches stay empty while the block is disabled;
- masked and level-sensitive lines never latch;
- edge-sensitive outputs stay low in recording mode except on a flush cycle;
- control reads never show the flush bit;
- writes outside the map leave the configuration untouched.

Only the bench scenarios can show the end-to-end behaviour:
- that the correct edge polarity is recorded;
- that the pulse pattern from a flush matches the edges the lines actually saw;
- that the set and clear windows map words and bits to the right lines;
- that an edge coinciding with a flush survives to be replayed.

// File: rtl/edge_rec_pkg.sv
package edge_rec_pkg;
  localparam int WORD_W     = 32;
  localparam int WORD_IDX_W = 4;
  localparam int BANK_SPAN  = 32'h40;
  localparam int NUM_BANKS  = 6;
  localparam logic [31:0] CTRL_OFF = 32'h300;

  localparam int CTL_EN    = 0;
  localparam int CTL_EDGE  = 1;
  localparam int CTL_FLUSH = 2;

  typedef enum logic [2:0] {
    BK_NONE      = 3'd0,
    BK_MASK_SET  = 3'd1,
    BK_MASK_CLR  = 3'd2,
    BK_SENSE_SET = 3'd3,
    BK_SENSE_CLR = 3'd4,
    BK_POL_SET   = 3'd5,
    BK_POL_CLR   = 3'd6,
    BK_CTRL      = 3'd7
  } bank_e;

  typedef struct packed {
    bank_e                 bank;
    logic [WORD_IDX_W-1:0] word;
  } decode_t;

  function automatic logic [31:0] bank_base(input int b);
    case (b)
      0:       bank_base = 32'h0C0;
      1:       bank_base = 32'h100;
      2:       bank_base = 32'h180;
      3:       bank_base = 32'h1C0;
      4:       bank_base = 32'h240;
      default: bank_base = 32'h280;
    endcase
  endfunction
endpackage

// File: rtl/edge_rec_decode.sv
module edge_rec_decode
  import edge_rec_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input  logic [ADDR_W-1:0] addr,
  output decode_t           dec
);
  logic [31:0] a_ext;
  logic [31:0] off;

  always_comb begin
    a_ext    = 32'(addr);
    off      = '0;
    dec.bank = BK_NONE;
    dec.word = '0;
    for (int b = 0; b < NUM_BANKS; b++) begin
      if (a_ext >= bank_base(b) && a_ext < bank_base(b) + 32'(BANK_SPAN) &&
          a_ext[1:0] == 2'b00) begin
        off      = a_ext - bank_base(b);
        dec.bank = bank_e'(3'(b + 1));
        dec.word = off[WORD_IDX_W+1:2];
      end
    end
    if (a_ext == CTRL_OFF) dec.bank = BK_CTRL;
  end
endmodule

// File: rtl/edge_rec_regs.sv
module edge_rec_regs
  import edge_rec_pkg::*;
#(
  parameter int NUM_LINES = 512
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 bus_wr,
  input  logic                 bus_rd,
  input  decode_t              dec,
  input  logic [WORD_W-1:0]    bus_wdata,
  output logic [WORD_W-1:0]    bus_rdata,
  output logic [NUM_LINES-1:0] mask_o,
  output logic [NUM_LINES-1:0] sense_o,
  output logic [NUM_LINES-1:0] pol_o,
  output logic                 en_o,
  output logic                 edge_o,
  output logic                 flush_o
);
  localparam int NWORDS = (NUM_LINES + WORD_W - 1) / WORD_W;
  localparam int PADW   = NWORDS * WORD_W;

  logic [PADW-1:0]   mask_q, sense_q, pol_q;
  logic [PADW-1:0]   spread;
  logic [PADW-1:0]   rd_src;
  logic [WORD_W-1:0] rd_word;
  logic [WORD_W-1:0] rdata_q;
  logic              en_q, edge_q, ctrl_rd_q;
  logic              word_ok;

  function automatic logic [WORD_W-1:0] valid_bits(input int w);
    for (int b = 0; b < WORD_W; b++) valid_bits[b] = (w * WORD_W + b < NUM_LINES);
  endfunction

  assign word_ok = (32'(dec.word) < 32'(NWORDS));

  // write data placed at its word position; only live lines can be touched
  always_comb begin
    spread = '0;
    if (bus_wr && word_ok) begin
      for (int w = 0; w < NWORDS; w++) begin
        if (32'(dec.word) == 32'(w)) spread[w*WORD_W +: WORD_W] = bus_wdata & valid_bits(w);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mask_q  <= '0;
      sense_q <= '0;
      pol_q   <= '0;
    end else begin
      if (dec.bank == BK_MASK_SET)  mask_q  <= mask_q  | spread;
      if (dec.bank == BK_MASK_CLR)  mask_q  <= mask_q  & ~spread;
      if (dec.bank == BK_SENSE_SET) sense_q <= sense_q | spread;
      if (dec.bank == BK_SENSE_CLR) sense_q <= sense_q & ~spread;
      if (dec.bank == BK_POL_SET)   pol_q   <= pol_q   | spread;
      if (dec.bank == BK_POL_CLR)   pol_q   <= pol_q   & ~spread;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q   <= 1'b0;
      edge_q <= 1'b0;
    end else if (bus_wr && dec.bank == BK_CTRL) begin
      en_q   <= bus_wdata[CTL_EN];
      edge_q <= bus_wdata[CTL_EDGE];
    end
  end

  // flush acts on the write cycle itself, using the mode held before the write
  assign flush_o = bus_wr && (dec.bank == BK_CTRL) && bus_wdata[CTL_FLUSH];

  always_comb begin
    case (dec.bank)
      BK_MASK_SET, BK_MASK_CLR:   rd_src = mask_q;
      BK_SENSE_SET, BK_SENSE_CLR: rd_src = sense_q;
      BK_POL_SET, BK_POL_CLR:     rd_src = pol_q;
      default:                    rd_src = '0;
    endcase
    rd_word = '0;
    for (int w = 0; w < NWORDS; w++) begin
      if (32'(dec.word) == 32'(w)) rd_word = rd_src[w*WORD_W +: WORD_W];
    end
    if (dec.bank == BK_CTRL) begin
      rd_word           = '0;
      rd_word[CTL_EN]   = en_q;
      rd_word[CTL_EDGE] = edge_q;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_q   <= '0;
      ctrl_rd_q <= 1'b0;
    end else begin
      ctrl_rd_q <= bus_rd && (dec.bank == BK_CTRL);
      if (bus_rd) rdata_q <= rd_word;
    end
  end

  assign bus_rdata = rdata_q;
  assign mask_o    = mask_q[NUM_LINES-1:0];
  assign sense_o   = sense_q[NUM_LINES-1:0];
  assign pol_o     = pol_q[NUM_LINES-1:0];
  assign en_o      = en_q;
  assign edge_o    = edge_q;

  assert_flush_reads_zero_R3: assert property (@(posedge clk) disable iff (rst)
    ctrl_rd_q |-> !bus_rdata[CTL_FLUSH]);

  assert_unmapped_write_ignored_R3: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && dec.bank == BK_NONE) |=> ($stable(mask_q) && $stable(sense_q) && $stable(pol_q)));
endmodule

// File: rtl/edge_rec_line.sv
module edge_rec_line (
  input  logic clk,
  input  logic rst,
  input  logic din,
  input  logic en,
  input  logic edge_mode,
  input  logic mask,
  input  logic sense,
  input  logic pol,
  input  logic flush,
  output logic dout
);
  logic s1_q, s2_q, prev_q, pend_q, out_q;
  logic rec, edge_hit, cap;

  assign rec      = en & edge_mode;
  assign edge_hit = pol ? (s2_q & ~prev_q) : (~s2_q & prev_q);
  assign cap      = rec & ~sense & ~mask & edge_hit;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_q   <= 1'b0;
      s2_q   <= 1'b0;
      prev_q <= 1'b0;
    end else begin
      s1_q   <= din;
      s2_q   <= s1_q;
      prev_q <= s2_q;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || !en) pend_q <= 1'b0;
    else            pend_q <= (pend_q & ~flush) | cap;
  end

  always_ff @(posedge clk) begin
    if (rst)                out_q <= 1'b0;
    else if (rec && !sense) out_q <= flush & pend_q;
    else                    out_q <= s2_q & ~mask;
  end

  assign dout = out_q;

  assert_flush_clears_R6: assert property (@(posedge clk) disable iff (rst)
    (flush && !cap) |=> !pend_q);

  assert_quiet_between_flush_R6: assert property (@(posedge clk) disable iff (rst)
    (rec && !sense && !flush) |=> !dout);

  assert_idle_clear_R4: assert property (@(posedge clk) disable iff (rst)
    !en |=> !pend_q);

  assert_mask_blocks_R7: assert property (@(posedge clk) disable iff (rst)
    (mask && !pend_q) |=> !pend_q);

  assert_level_no_latch_R8: assert property (@(posedge clk) disable iff (rst)
    (sense && !pend_q) |=> !pend_q);
endmodule

// File: rtl/edge_rec_top.sv
module edge_rec_top
  import edge_rec_pkg::*;
#(
  parameter int NUM_LINES = 512,
  parameter int ADDR_W    = 12
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 bus_wr,
  input  logic                 bus_rd,
  input  logic [ADDR_W-1:0]    bus_addr,
  input  logic [31:0]          bus_wdata,
  output logic [31:0]          bus_rdata,
  input  logic [NUM_LINES-1:0] irq_in,
  output logic [NUM_LINES-1:0] irq_out
);
  decode_t              dec;
  logic [NUM_LINES-1:0] mask_v, sense_v, pol_v;
  logic                 en, edge_mode, flush;

  edge_rec_decode #(.ADDR_W(ADDR_W)) u_dec (
    .addr (bus_addr),
    .dec  (dec)
  );

  edge_rec_regs #(.NUM_LINES(NUM_LINES)) u_regs (
    .clk       (clk),
    .rst       (rst),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .dec       (dec),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .mask_o    (mask_v),
    .sense_o   (sense_v),
    .pol_o     (pol_v),
    .en_o      (en),
    .edge_o    (edge_mode),
    .flush_o   (flush)
  );

  for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
    edge_rec_line u_line (
      .clk       (clk),
      .rst       (rst),
      .din       (irq_in[i]),
      .en        (en),
      .edge_mode (edge_mode),
      .mask      (mask_v[i]),
      .sense     (sense_v[i]),
      .pol       (pol_v[i]),
      .flush     (flush),
      .dout      (irq_out[i])
    );
  end
endmodule

// File: tb/sim_edge_rec_top.sv
module sim_edge_rec_top;
  localparam int CLK_PERIOD = 10;
  localparam int NL = 64;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          bus_wr = 1'b0, bus_rd = 1'b0;
  logic [11:0]   bus_addr = '0;
  logic [31:0]   bus_wdata = '0;
  logic [31:0]   bus_rdata;
  logic [NL-1:0] irq_in = '0;
  logic [NL-1:0] irq_out;

  edge_rec_top #(.NUM_LINES(NL), .ADDR_W(12)) u0 (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_in(irq_in), .irq_out(irq_out)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0, fails = 0;
  bit done = 0;
  logic [NL-1:0] m_mask = '0, m_sense = '0, m_pol = '0, m_pend = '0, in_v = '0;
  logic m_en = 0, m_edge = 0;

  function automatic logic [11:0] bank_addr(int b, int w);
    int base [6] = '{'h0C0, 'h100, 'h180, 'h1C0, 'h240, 'h280};
    return 12'(base[b] + 4 * w);
  endfunction

  task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic model_write(logic [11:0] a, logic [31:0] d);
    for (int b = 0; b < 6; b++) begin
      if (a >= bank_addr(b, 0) && a < bank_addr(b, 16) && a[1:0] == 2'b00) begin
        int w = (int'(a) - int'(bank_addr(b, 0))) / 4;
        if (w < NL / 32) begin
          logic [NL-1:0] sp = NL'(d) << (32 * w);
          case (b)
            0: m_mask  = m_mask | sp;   1: m_mask  = m_mask & ~sp;
            2: m_sense = m_sense | sp;  3: m_sense = m_sense & ~sp;
            4: m_pol   = m_pol | sp;    default: m_pol = m_pol & ~sp;
          endcase
        end
      end
    end
    if (a == 12'h300) begin
      m_en = d[0]; m_edge = d[1];
      if (!m_en) m_pend = '0;
    end
  endtask

  function automatic logic [31:0] model_read(logic [11:0] a);
    for (int b = 0; b < 6; b++) begin
      if (a >= bank_addr(b, 0) && a < bank_addr(b, 16) && a[1:0] == 2'b00) begin
        int w = (int'(a) - int'(bank_addr(b, 0))) / 4;
        if (w >= NL / 32) return '0;
        if (b < 2) return m_mask[32*w +: 32];
        if (b < 4) return m_sense[32*w +: 32];
        return m_pol[32*w +: 32];
      end
    end
    if (a == 12'h300) return {30'b0, m_edge, m_en};
    return '0;
  endfunction

  task automatic bus_write(logic [11:0] a, logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic cfg_write(logic [11:0] a, logic [31:0] d);
    bus_write(a, d);
    model_write(a, d);
  endtask

  task automatic bus_read(logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic read_check(string tag, logic [11:0] a);
    logic [31:0] d;
    bus_read(a, d);
    check(tag, 64'(d), 64'(model_read(a)));
  endtask

  task automatic set_lines(logic [NL-1:0] nv);
    if (m_en && m_edge) begin
      for (int i = 0; i < NL; i++) begin
        if (!m_sense[i] && !m_mask[i]) begin
          if (m_pol[i] ? (!in_v[i] && nv[i]) : (in_v[i] && !nv[i])) m_pend[i] = 1'b1;
        end
      end
    end
    @(negedge clk);
    irq_in = nv; in_v = nv;
    repeat (4) @(negedge clk);
  endtask

  function automatic logic [NL-1:0] pass_exp();
    if (m_en && m_edge) return m_sense & in_v & ~m_mask;
    return in_v & ~m_mask;
  endfunction

  // flush in recording mode: pulse pattern, then quiet edge lines
  task automatic do_flush(string tag);
    bus_write(12'h300, {29'b0, 1'b1, m_edge, m_en});
    check({tag, " flush pulse"}, 64'(irq_out), 64'((m_sense & in_v & ~m_mask) | (~m_sense & m_pend)));
    m_pend = '0;
    @(negedge clk);
    check({tag, " after flush"}, 64'(irq_out), 64'(pass_exp()));
  endtask

  initial begin
    void'($urandom(32'h5EED_1234));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1 reset state
    check("R1 out after reset", 64'(irq_out), 64'(0));
    read_check("R1 mask reset", bank_addr(0, 0));
    read_check("R1 sense reset", bank_addr(3, 1));
    read_check("R1 ctrl reset", 12'h300);

    // R2/R3 random configuration writes with readback through both windows
    for (int k = 0; k < 40; k++) begin
      int b = $urandom_range(0, 5);
      int w = $urandom_range(0, 1);
      cfg_write(bank_addr(b, w), $urandom);
      read_check("R2 bank readback", bank_addr($urandom_range(0, 5), $urandom_range(0, 1)));
    end
    cfg_write(bank_addr(0, 0), 32'h0000_00F0);
    cfg_write(bank_addr(1, 0), 32'h0000_0030);
    read_check("R2 set then clear mask word0", bank_addr(1, 0));
    cfg_write(bank_addr(4, 1), 32'h0);
    read_check("R2 zero bits no effect", bank_addr(5, 1));

    // R3 unmapped addresses and out-of-range words
    cfg_write(12'h000, 32'hFFFF_FFFF);
    cfg_write(12'h3FC, 32'hFFFF_FFFF);
    cfg_write(bank_addr(0, 2), 32'hFFFF_FFFF);
    cfg_write(bank_addr(2, 0) + 12'd1, 32'hFFFF_FFFF);
    read_check("R3 unmapped read zero", 12'h000);
    read_check("R3 beyond-line word zero", bank_addr(0, 2));
    read_check("R3 mask word0 unchanged", bank_addr(0, 0));
    read_check("R3 mask word1 unchanged", bank_addr(1, 1));
    read_check("R3 sense word0 unchanged", bank_addr(2, 0));
    cfg_write(12'h300, 32'h2);
    read_check("R3 ctrl readback edge-only", 12'h300);
    cfg_write(12'h300, 32'h0);

    // R4/R7 pass-through while disabled
    for (int k = 0; k < 8; k++) begin
      set_lines({$urandom, $urandom});
      check("R4 R7 disabled pass-through", 64'(irq_out), 64'(pass_exp()));
    end

    // R10 enable without edge-only
    cfg_write(12'h300, 32'h1);
    for (int k = 0; k < 4; k++) begin
      set_lines({$urandom, $urandom});
      check("R10 enable-only pass-through", 64'(irq_out), 64'(pass_exp()));
    end
    cfg_write(12'h300, 32'h3);
    do_flush("R10 nothing recorded");

    // directed setup: all lines edge, unmasked, 0..15 rising, rest falling
    cfg_write(12'h300, 32'h0);
    cfg_write(bank_addr(1, 0), 32'hFFFF_FFFF); cfg_write(bank_addr(1, 1), 32'hFFFF_FFFF);
    cfg_write(bank_addr(3, 0), 32'hFFFF_FFFF); cfg_write(bank_addr(3, 1), 32'hFFFF_FFFF);
    cfg_write(bank_addr(5, 0), 32'hFFFF_FFFF); cfg_write(bank_addr(5, 1), 32'hFFFF_FFFF);
    cfg_write(bank_addr(4, 0), 32'h0000_FFFF);
    set_lines('0);
    cfg_write(12'h300, 32'h3);

    // R5 polarity selects the edge
    set_lines(in_v | (64'd1 << 3) | (64'd1 << 20));
    check("R5 edge line quiet before flush", 64'(irq_out), 64'(0));
    do_flush("R5 rising on pol1 only");
    set_lines(in_v & ~(64'd1 << 20) & ~(64'd1 << 3));
    do_flush("R5 falling on pol0 only");
    do_flush("R6 second flush empty");

    // R7 masked line in recording mode
    cfg_write(bank_addr(0, 0), 32'h20);
    set_lines(in_v | (64'd1 << 5));
    do_flush("R7 masked no latch");
    cfg_write(bank_addr(1, 0), 32'h20);

    // R8 level line passes through in recording mode
    cfg_write(bank_addr(2, 0), 32'h80);
    set_lines(in_v | (64'd1 << 7));
    check("R8 level high passes", 64'(irq_out), 64'(64'd1 << 7));
    set_lines(in_v & ~(64'd1 << 7));
    check("R8 level low passes", 64'(irq_out), 64'(0));
    do_flush("R8 level no latch");

    // R9 edge coincident with flush
    begin
      logic first, second;
      @(negedge clk);
      irq_in[9] = 1'b1; in_v[9] = 1'b1;
      @(negedge clk);
      bus_write(12'h300, 32'h7);
      first = irq_out[9];
      repeat (3) @(negedge clk);
      bus_write(12'h300, 32'h7);
      second = irq_out[9];
      check("R9 coincident edge replayed once", 64'(first ^ second), 64'(1));
      m_pend = '0;
      repeat (2) @(negedge clk);
    end

    // R5/R6/R7/R8 random recording traffic
    for (int k = 0; k < 40; k++) begin
      if ($urandom_range(0, 3) == 0) cfg_write(bank_addr($urandom_range(0, 5), $urandom_range(0, 1)), $urandom);
      set_lines(in_v ^ ({$urandom, $urandom} & {$urandom, $urandom}));
      check("R8 R6 recording idle outputs", 64'(irq_out), 64'(pass_exp()));
      if (k % 3 == 2) do_flush("R5 R6 random flush");
    end
    do_flush("R6 final random flush");

    // R4 disabling discards pending events
    cfg_write(bank_addr(1, 0), 32'hFFFF_FFFF); cfg_write(bank_addr(1, 1), 32'hFFFF_FFFF);
    cfg_write(bank_addr(3, 0), 32'hFFFF_FFFF); cfg_write(bank_addr(3, 1), 32'hFFFF_FFFF);
    cfg_write(bank_addr(4, 0), 32'hFFFF_FFFF); cfg_write(bank_addr(4, 1), 32'hFFFF_FFFF);
    set_lines('0);
    set_lines('1);
    cfg_write(12'h300, 32'h0);
    cfg_write(12'h300, 32'h3);
    do_flush("R4 latches cleared by disable");

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL R6 watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule